// File: doc/BRIEF.md
# Parallel NOR Flash Command Engine

This block is a synthesizable model of a byte-wide parallel NOR flash. The host reaches it through a chip-select, write-strobe and read-strobe bus, which is sampled on the system clock. Commands arrive as short unlock sequences. A control state machine decodes them and runs timed embedded operations: single-byte program, erase of chosen sectors, and erase of the whole chip. The host learns that an operation has finished by polling two status bits in the read data.

The array depth is set by `ADDR_W`. The default of 11 gives 2 KB, and a value of 17 gives the full 128 KB part. The top `SECT_BITS` address bits select one of the uniform sectors, eight by default. Each sector can be locked through an input mask. An erase can be paused so that the host can read the sectors that are not being erased, and then continued. A low-supply input blocks every write cycle while it is high. Program, erase pulse and sector-collection window lengths are given as clock-cycle parameters.

Top module: `flash_engine`

## Requirements
- R1: While `rstN` is low, `dqOut` is 0x00 and the engine is in array-read mode. `dqOe` is high exactly when `ceN` and `oeN` are both low.
- R2: A write cycle is accepted on the clock edge that first sees `weN` high after low while `ceN` is low. A read is taken on the edge that first sees `oeN` low while `ceN` is low, and its byte is on `dqOut` from that edge on.
- R3: A command begins with byte 0xAA written to address 0x555 and byte 0x55 written to address 0x2AA, using the low 11 address bits. Any other write in these positions, including 0xF0, returns the engine to array-read mode with no effect.
- R4: After 0xA0, the next write programs one byte. The stored value becomes old AND new, and it is written when `PGM_CYC` cycles have passed.
- R5: While busy, a read returns a status byte. Bit 7 is the complement of bit 7 of the byte being programmed, or 0 during an erase. Bit 6 inverts on every read. Bits 5..0 are 0. Once the operation is done, reads return array data.
- R6: Chip erase (0x80, a second unlock, then 0x10) first writes 0x00 to every byte of the unprotected sectors. It then waits `ERS_CYC` cycles and then fills those bytes with 0xFF.
- R7: Sector erase (0x80, a second unlock, then 0x30 written to an address in the sector) opens a window of `WIN_CYC` cycles. Each further 0x30 write adds its sector and restarts the window. Any other write cancels the erase. When the window expires, the erase starts. Sectors not selected keep their data.
- R8: When `protMask[i]` is 1, sector i cannot be changed. A program aimed at it is dropped and the engine does not go busy. An erase skips it, and an erase whose only targets are locked sectors returns to array-read mode when the window ends.
- R9: Writing 0xB0 during an erase pauses it. While paused, reads of sectors not being erased return array data, and reads of sectors being erased return 0x80. Writing 0x30 continues the erase to completion.
- R10: While `lowVcc` is high, every write cycle is ignored.
- R11: During a program, every write cycle is ignored. During an erase, only 0xB0 has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low; a cycle is taken on its rising edge |
| oeN | input | 1 | Read strobe, active low |
| lowVcc | input | 1 | Low-supply flag; blocks all writes while high |
| protMask | input | 2**SECT_BITS | Per-sector lock, bit i locks sector i |
| addr | input | ADDR_W | Byte address |
| dqIn | input | 8 | Write data / command byte |
| dqOut | output | 8 | Read data or status byte |
| dqOe | output | 1 | Read-data drive enable |

## Verification
The assertions assume that `protMask` does not change while an operation is running, that the bus pins change away from the rising clock edge, and that address and data stay stable from the start of a write cycle until `weN` rises. The bench drives every bus pin on the falling clock edge and never has both strobes low at once. It changes the lock mask only while the engine is idle in array-read mode. Completion is detected with the toggle-bit method: the bench reads the same address twice and waits for two equal bytes.

// File: rtl/flash_pkg.sv
package flash_pkg;
  // Width of the address slice used for unlock decoding
  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] UNLOCK_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] UNLOCK_ADDR_B = 11'h2AA;

  localparam logic [7:0] KEY_A       = 8'hAA;
  localparam logic [7:0] KEY_B       = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASE    = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_PAUSE    = 8'hB0;
  localparam logic [7:0] OP_CONTINUE = 8'h30;
  localparam logic [7:0] PAUSED_BYTE = 8'h80;

  typedef enum logic [3:0] {
    ST_READ, ST_KEY1, ST_KEY2, ST_PGM_DATA,
    ST_EKEY0, ST_EKEY1, ST_ESEL, ST_EWIN,
    ST_PGM_BUSY, ST_PRE, ST_PULSE, ST_FILL, ST_PAUSED
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWr;    // write one array byte this cycle
    logic andMode;  // 1: store old & data, 0: store data
    logic rdReq;    // host read strobe seen
    logic busy;     // embedded operation running
    logic pollBit;  // value for bit 7 of status
    logic paused;   // erase on hold
  } dpStrobe_t;
endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_BITS = 3,
  parameter int PGM_CYC   = 8,
  parameter int ERS_CYC   = 16,
  parameter int WIN_CYC   = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceN,
  input  logic                    weN,
  input  logic                    oeN,
  input  logic                    lowVcc,
  input  logic [(1<<SECT_BITS)-1:0] protMask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              dqIn,
  output dpStrobe_t               strb,
  output logic [ADDR_W-1:0]       wrAddr,
  output logic [7:0]              wrData,
  output logic [(1<<SECT_BITS)-1:0] sectMask
);
  localparam int NSECT = 1 << SECT_BITS;
  localparam int CNT_W = $clog2(PGM_CYC + ERS_CYC + WIN_CYC + 1) + 1;

  function automatic logic [SECT_BITS-1:0] sectOf(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_BITS];
  endfunction

  ctrlState_t        state, resumeState;
  logic              weQ, oeQ;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] walk, pgmAddr;
  logic [7:0]        pgmData;
  logic [NSECT-1:0]  mask, sectBit;
  logic weRise, wrOk, oeFall, keyAHit, keyBHit, pauseHit;

  assign weRise   = weN & ~weQ & ~ceN;
  assign wrOk     = weRise & ~lowVcc;
  assign oeFall   = ~oeN & oeQ & ~ceN;
  assign keyAHit  = (addr[CMD_AW-1:0] == UNLOCK_ADDR_A) && (dqIn == KEY_A);
  assign keyBHit  = (addr[CMD_AW-1:0] == UNLOCK_ADDR_B) && (dqIn == KEY_B);
  assign pauseHit = wrOk && (dqIn == OP_PAUSE);
  assign sectBit  = NSECT'(1) << sectOf(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_READ;
      resumeState <= ST_READ;
      weQ         <= 1'b1;
      oeQ         <= 1'b1;
      cnt         <= '0;
      walk        <= '0;
      pgmAddr     <= '0;
      pgmData     <= '0;
      mask        <= '0;
    end else begin
      weQ <= weN;
      oeQ <= oeN;
      unique case (state)
        ST_READ:  if (wrOk && keyAHit) state <= ST_KEY1;
        ST_KEY1:  if (wrOk) state <= keyBHit ? ST_KEY2 : ST_READ;
        ST_KEY2:  if (wrOk) begin
          if (dqIn == OP_PROGRAM)    state <= ST_PGM_DATA;
          else if (dqIn == OP_ERASE) state <= ST_EKEY0;
          else                       state <= ST_READ;
        end
        ST_PGM_DATA: if (wrOk) begin
          if (protMask[sectOf(addr)]) state <= ST_READ;
          else begin
            pgmAddr <= addr;
            pgmData <= dqIn;
            cnt     <= CNT_W'(PGM_CYC - 1);
            state   <= ST_PGM_BUSY;
          end
        end
        ST_EKEY0: if (wrOk) state <= keyAHit ? ST_EKEY1 : ST_READ;
        ST_EKEY1: if (wrOk) state <= keyBHit ? ST_ESEL : ST_READ;
        ST_ESEL:  if (wrOk) begin
          if (dqIn == OP_CHIP) begin
            mask  <= ~protMask;
            walk  <= '0;
            state <= ST_PRE;
          end else if (dqIn == OP_SECTOR) begin
            mask  <= sectBit & ~protMask;
            cnt   <= CNT_W'(WIN_CYC - 1);
            state <= ST_EWIN;
          end else state <= ST_READ;
        end
        ST_EWIN: begin
          if (wrOk) begin
            if (dqIn == OP_SECTOR) begin
              mask <= mask | (sectBit & ~protMask);
              cnt  <= CNT_W'(WIN_CYC - 1);
            end else state <= ST_READ;
          end else if (cnt == '0) begin
            walk  <= '0;
            state <= (mask == '0) ? ST_READ : ST_PRE;
          end else cnt <= cnt - 1'b1;
        end
        ST_PGM_BUSY: if (cnt == '0) state <= ST_READ; else cnt <= cnt - 1'b1;
        ST_PRE: begin
          if (pauseHit) begin
            resumeState <= ST_PRE;
            state       <= ST_PAUSED;
          end else if (walk == '1) begin
            cnt   <= CNT_W'(ERS_CYC - 1);
            state <= ST_PULSE;
          end else walk <= walk + 1'b1;
        end
        ST_PULSE: begin
          if (pauseHit) begin
            resumeState <= ST_PULSE;
            state       <= ST_PAUSED;
          end else if (cnt == '0) begin
            walk  <= '0;
            state <= ST_FILL;
          end else cnt <= cnt - 1'b1;
        end
        ST_FILL: begin
          if (pauseHit) begin
            resumeState <= ST_FILL;
            state       <= ST_PAUSED;
          end else if (walk == '1) state <= ST_READ;
          else walk <= walk + 1'b1;
        end
        ST_PAUSED: if (wrOk && dqIn == OP_CONTINUE) state <= resumeState;
        default: state <= ST_READ;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.rdReq   = oeFall;
    strb.busy    = state inside {ST_PGM_BUSY, ST_EWIN, ST_PRE, ST_PULSE, ST_FILL};
    strb.pollBit = (state == ST_PGM_BUSY) ? ~pgmData[7] : 1'b0;
    strb.paused  = (state == ST_PAUSED);
    strb.andMode = (state != ST_FILL);
    if (state == ST_PGM_BUSY) strb.memWr = (cnt == '0);
    else if (state == ST_PRE || state == ST_FILL) strb.memWr = mask[sectOf(walk)] && !pauseHit;
    wrAddr = (state == ST_PGM_BUSY) ? pgmAddr : walk;
    if (state == ST_PGM_BUSY)  wrData = pgmData;
    else if (state == ST_FILL) wrData = 8'hFF;
    else                       wrData = 8'h00;
  end

  assign sectMask = mask;

  a_r8_no_locked_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.memWr |-> !protMask[sectOf(wrAddr)]);
  a_r10_low_supply_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && weRise && lowVcc) |=> state == ST_READ);
  a_r11_pgm_ignores_bus: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PGM_BUSY && cnt != '0) |=> state == ST_PGM_BUSY);
  a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAUSED && !(wrOk && dqIn == OP_CONTINUE)) |=> state == ST_PAUSED);
endmodule

// File: rtl/flash_datapath.sv
module flash_datapath
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_BITS = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [7:0]              wrData,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [(1<<SECT_BITS)-1:0] sectMask,
  output logic [7:0]              dqOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic       toggleQ;
  logic [SECT_BITS-1:0] rdSect;

  assign rdSect = rdAddr[ADDR_W-1 -: SECT_BITS];

  always_ff @(posedge clk) begin
    if (strb.memWr)
      mem[wrAddr] <= strb.andMode ? (mem[wrAddr] & wrData) : wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOut   <= 8'h00;
      toggleQ <= 1'b0;
    end else if (strb.rdReq) begin
      if (strb.busy) begin
        dqOut   <= {strb.pollBit, ~toggleQ, 6'b0};
        toggleQ <= ~toggleQ;
      end else if (strb.paused && sectMask[rdSect]) begin
        dqOut <= PAUSED_BYTE;
      end else begin
        dqOut <= mem[rdAddr];
      end
    end
  end

  a_r5_status_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdReq && strb.busy) |=> dqOut[5:0] == 6'b0);
endmodule

// File: rtl/flash_engine.sv
module flash_engine
  import flash_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int SECT_BITS = 3,
  parameter int PGM_CYC   = 8,
  parameter int ERS_CYC   = 16,
  parameter int WIN_CYC   = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ceN,
  input  logic                      weN,
  input  logic                      oeN,
  input  logic                      lowVcc,
  input  logic [(1<<SECT_BITS)-1:0] protMask,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                dqIn,
  output logic [7:0]                dqOut,
  output logic                      dqOe
);
  dpStrobe_t                 strb;
  logic [ADDR_W-1:0]         wrAddr;
  logic [7:0]                wrData;
  logic [(1<<SECT_BITS)-1:0] sectMask;

  flash_ctrl #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
    .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .WIN_CYC(WIN_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .lowVcc(lowVcc), .protMask(protMask), .addr(addr), .dqIn(dqIn),
    .strb(strb), .wrAddr(wrAddr), .wrData(wrData), .sectMask(sectMask)
  );

  flash_datapath #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(addr), .sectMask(sectMask), .dqOut(dqOut)
  );

  assign dqOe = ~ceN & ~oeN;
endmodule

// File: tb/flash_engine_bench.sv
module flash_engine_bench;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, lowVcc = 1'b0;
  logic [7:0] protMask = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0] dqIn = 8'h00;
  logic [7:0] dqOut;
  logic dqOe;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  flash_engine u_flash_engine (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .lowVcc(lowVcc),
    .protMask(protMask), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  // {address, data programmed, expected read-back}
  localparam logic [26:0] PGM_VEC [8] = '{
    {11'h010, 8'h5A, 8'h5A}, {11'h010, 8'h0F, 8'h0A},
    {11'h2FF, 8'h00, 8'h00}, {11'h300, 8'h81, 8'h81},
    {11'h7FF, 8'h3C, 8'h3C}, {11'h555, 8'hC3, 8'hC3},
    {11'h101, 8'hF0, 8'hF0}, {11'h300, 8'h7E, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; addr = a; dqIn = d;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; addr = a;
    @(negedge clk); d = dqOut; oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic unlock();
    busWrite(11'h555, 8'hAA);
    busWrite(11'h2AA, 8'h55);
  endtask

  task automatic cmdProgram(input logic [AW-1:0] a, input logic [7:0] d);
    unlock(); busWrite(11'h555, 8'hA0); busWrite(a, d);
  endtask

  task automatic cmdEraseSetup();
    unlock(); busWrite(11'h555, 8'h80); unlock();
  endtask

  task automatic waitReady(input string tag, input logic [AW-1:0] a);
    logic [7:0] x, y;
    bit done = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) begin
      busRead(a, x); busRead(a, y);
      if (x == y) done = 1'b1;
    end
    tests++;
    if (!done) begin
      fails++;
      $display("FAIL %s completion actual=busy expected=ready", tag);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2;
    // R1: reset state
    idle(3);
    check("R1 reset dqOut", dqOut, 8'h00);
    check("R1 dqOe idle", {7'b0, dqOe}, 8'h00);
    rstN = 1'b1;
    idle(2);
    ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    check("R1 R2 dqOe on read", {7'b0, dqOe}, 8'h01);
    ceN = 1'b1; oeN = 1'b1;
    idle(2);

    // R6 chip erase with status R5
    cmdEraseSetup(); busWrite(11'h555, 8'h10);
    busRead(11'h000, d1); busRead(11'h000, d2);
    check("R5 erase status bits", d1 & 8'hBF, 8'h00);
    check("R5 toggle inverts", {7'b0, d2[6]}, {7'b0, ~d1[6]});
    waitReady("R6 chip erase", 11'h000);
    busRead(11'h000, d1); check("R6 first byte", d1, 8'hFF);
    busRead(11'h7FF, d1); check("R6 last byte", d1, 8'hFF);
    busRead(11'h100, d1); check("R6 sector1 base", d1, 8'hFF);
    busRead(11'h4FF, d1); check("R6 sector4 top", d1, 8'hFF);

    // R4 table-driven programs, R5 data polling
    for (int i = 0; i < 8; i++) begin
      logic [26:0] v;
      v = PGM_VEC[i];
      cmdProgram(v[26:16], v[15:8]);
      busRead(v[26:16], d1);
      check("R5 poll bit", {7'b0, d1[7]}, {7'b0, ~v[15]});
      waitReady("R4 program", v[26:16]);
      busRead(v[26:16], d1);
      check("R4 stored value", d1, v[7:0]);
    end

    // R8 program into locked sector 2 is dropped
    protMask = 8'h04;
    cmdProgram(11'h205, 8'h00);
    busRead(11'h205, d1); check("R8 locked program", d1, 8'hFF);
    busRead(11'h205, d2); check("R8 no busy", d2, d1);

    // R7 multi-sector erase with locked sector 2
    cmdEraseSetup(); busWrite(11'h100, 8'h30);
    busWrite(11'h200, 8'h30); busWrite(11'h300, 8'h30);
    busRead(11'h000, d1); check("R7 R5 window status", d1 & 8'hBF, 8'h00);
    waitReady("R7 sector erase", 11'h000);
    busRead(11'h101, d1); check("R7 sector1 erased", d1, 8'hFF);
    busRead(11'h300, d1); check("R7 sector3 erased", d1, 8'hFF);
    busRead(11'h2FF, d1); check("R8 locked sector kept", d1, 8'h00);
    busRead(11'h010, d1); check("R7 sector0 kept", d1, 8'h0A);

    // R8 erase of a locked sector only
    cmdEraseSetup(); busWrite(11'h200, 8'h30);
    idle(20);
    busRead(11'h2FF, d1); check("R8 locked-only erase", d1, 8'h00);

    // R7 window cancelled by another write
    cmdEraseSetup(); busWrite(11'h000, 8'h30); busWrite(11'h000, 8'hF0);
    idle(20);
    busRead(11'h010, d1); check("R7 window cancel", d1, 8'h0A);
    protMask = 8'h00;

    // R9 pause and continue
    cmdEraseSetup(); busWrite(11'h500, 8'h30);
    idle(30);
    busWrite(11'h000, 8'hB0);
    busRead(11'h7FF, d1); check("R9 other sector read", d1, 8'h3C);
    busRead(11'h555, d1); check("R9 erasing sector read", d1, 8'h80);
    idle(50);
    busRead(11'h555, d1); check("R9 still paused", d1, 8'h80);
    busWrite(11'h000, 8'h30);
    busRead(11'h000, d1); check("R9 busy after continue", d1 & 8'hBF, 8'h00);
    waitReady("R9 continued erase", 11'h000);
    busRead(11'h555, d1); check("R9 sector5 erased", d1, 8'hFF);
    busRead(11'h7FF, d1); check("R9 sector7 kept", d1, 8'h3C);

    // R10 low supply blocks writes
    lowVcc = 1'b1;
    cmdProgram(11'h7FF, 8'h00);
    lowVcc = 1'b0;
    busRead(11'h7FF, d1); check("R10 low supply", d1, 8'h3C);

    // R3 broken unlock sequences
    unlock(); busWrite(11'h555, 8'hF0); busWrite(11'h7FF, 8'h00);
    busRead(11'h7FF, d1); check("R3 reset command", d1, 8'h3C);
    busWrite(11'h555, 8'hAA); busWrite(11'h2AA, 8'h54);
    busWrite(11'h555, 8'hA0); busWrite(11'h7FF, 8'h00);
    busRead(11'h7FF, d1); check("R3 wrong key", d1, 8'h3C);

    // R11 writes ignored during program
    cmdProgram(11'h7FF, 8'h0F);
    busWrite(11'h000, 8'hB0);
    busRead(11'h7FF, d1); check("R11 still busy", d1 & 8'hBF, 8'h80);
    waitReady("R11 program", 11'h7FF);
    busRead(11'h7FF, d1); check("R11 program result", d1, 8'h0C);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule